// File: doc/BRIEF.md
# Prioritised Vectoring Interrupt Controller

This block gathers thirteen interrupt request lines, numbered 1 to 13, and presents one of them to the processor as a 3-bit interrupt level and an 8-bit vector number. Each source has three pieces of state: a pending bit, a mask bit and an 8-bit control byte. The control byte holds the source's level, a two-bit priority within that level, and a flag that selects autovectoring. The pending bit samples the request input on every clock.

On every cycle the controller looks at all sources that are pending and not masked. It compares the low five bits of their control bytes, which hold the level and the priority together. The largest value wins, and a tie goes to the lower-numbered source. A winner whose level is zero is not presented. The vector is either the autovector (24 plus the level) or a value taken from a programmable register. One such register serves source 8, and two more serve sources 12 and 13. Every other source falls back to a fixed vector.

Software programs the controller through a simple register port: a write strobe, an address, write data, and combinational read data. Both outputs are registered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0x3FFE (every source masked), the watchdog vector register reads 0x0F, both serial vector registers read 0x00, and irq_level and irq_vector are 0.
- R2: After reset the control bytes for sources 1 to 7 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C. Source 8 reads 0x1C, sources 9 to 11 read 0x80, and sources 12 and 13 read 0x00.
- R3: The control byte layout is as follows: bit 7 enables the autovector, bits 4:2 hold the level, and bits 1:0 hold the priority. Among the sources that are pending and unmasked, the one with the largest control bits 4:0 is presented, and irq_level equals its bits 4:2.
- R4: When two candidates have equal control bits 4:0, the lower-numbered source wins.
- R5: If the winning bits 4:0 are below 4 (level 0), or if there is no candidate, irq_level and irq_vector are both 0.
- R6: Mask bit n belongs to source n, and a 1 masks the source. A masked source never wins. Writes to mask bit 0 are ignored.
- R7: When the winner's control bit 7 is set, irq_vector is 24 plus its level.
- R8: When bit 7 is clear, source 8 uses the watchdog vector register, source 12 uses serial vector 0, source 13 uses serial vector 1, and any other source uses 0x0F.
- R9: Pending bit n shows the request input n as it was sampled on the previous clock edge. Writes to the pending address have no effect.
- R10: After a register write is captured on a clock edge, the outputs reflect it on the next edge. After a request change, the outputs reflect it on the second edge.
- R11: The register map is as follows. The control byte for source n is at address n (1 to 13). The mask is at 0x10, pending at 0x11, the watchdog vector at 0x12, serial vector 0 at 0x13 and serial vector 1 at 0x14. Data bit n of the mask and pending registers is source n. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 13 | Request lines; bit n is source n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_level | output | 3 | Presented interrupt level, 0 for none |
| irq_vector | output | 8 | Presented vector number, 0 for none |

## Verification
The assertions assume that reg_addr, reg_wdata and src_req are free of X whenever reg_we is high or the clock edges. They also assume that reset is applied before the first write. The stimulus drives all inputs only on falling edges and never leaves them undefined. It holds reset for several cycles, and it waits for a full settle of three rising edges before it compares an expected level and vector. The only exception is the latency check, which samples the outputs on purpose one edge early and then again one edge later.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC_DEF = 13;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int CTRL_W = 8;
  localparam int VEC_W = 8;
  localparam int LVL_W = 3;
  localparam int KEY_W = 5;

  localparam logic [ADDR_W-1:0] ADR_MASK = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_PEND = 5'h11;
  localparam logic [ADDR_W-1:0] ADR_WDV  = 5'h12;
  localparam logic [ADDR_W-1:0] ADR_SV0  = 5'h13;
  localparam logic [ADDR_W-1:0] ADR_SV1  = 5'h14;

  localparam logic [VEC_W-1:0] FALLBACK_VEC = 8'h0F;
  localparam logic [VEC_W-1:0] AUTOVEC_BASE = 8'd24;
  localparam logic [KEY_W-1:0] MIN_KEY = 5'd4;

  function automatic logic [CTRL_W-1:0] ctrl_reset(input int n);
    if (n >= 1 && n <= 7) return CTRL_W'(n * 4);
    else if (n == 8) return 8'h1C;
    else if (n >= 9 && n <= 11) return 8'h80;
    else return 8'h00;
  endfunction
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NSRC = NSRC_DEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC:1]               src_req,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NSRC:1][CTRL_W-1:0]   ctrl_o,
  output logic [NSRC:1]               mask_o,
  output logic [NSRC:1]               pend_o,
  output logic [VEC_W-1:0]            wdv_o,
  output logic [VEC_W-1:0]            sv0_o,
  output logic [VEC_W-1:0]            sv1_o
);
  logic [NSRC:1][CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NSRC:1]             mask_q, mask_d, pend_q;
  logic [VEC_W-1:0]          wdv_q, wdv_d, sv0_q, sv0_d, sv1_q, sv1_d;
  logic                      ready_q;

  always_comb begin
    ctrl_d = ctrl_q;
    mask_d = mask_q;
    wdv_d  = wdv_q;
    sv0_d  = sv0_q;
    sv1_d  = sv1_q;
    if (we) begin
      for (int n = 1; n <= NSRC; n++)
        if (addr == ADDR_W'(n)) ctrl_d[n] = wdata[CTRL_W-1:0];
      if (addr == ADR_MASK) mask_d = wdata[NSRC:1];
      if (addr == ADR_WDV)  wdv_d  = wdata[VEC_W-1:0];
      if (addr == ADR_SV0)  sv0_d  = wdata[VEC_W-1:0];
      if (addr == ADR_SV1)  sv1_d  = wdata[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 1; n <= NSRC; n++) ctrl_q[n] <= ctrl_reset(n);
      mask_q  <= '1;
      pend_q  <= '0;
      wdv_q   <= FALLBACK_VEC;
      sv0_q   <= '0;
      sv1_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      mask_q  <= mask_d;
      pend_q  <= src_req;
      wdv_q   <= wdv_d;
      sv0_q   <= sv0_d;
      sv1_q   <= sv1_d;
      ready_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    for (int n = 1; n <= NSRC; n++)
      if (addr == ADDR_W'(n)) rdata[CTRL_W-1:0] = ctrl_q[n];
    case (addr)
      ADR_MASK: rdata[NSRC:1]    = mask_q;
      ADR_PEND: rdata[NSRC:1]    = pend_q;
      ADR_WDV:  rdata[VEC_W-1:0] = wdv_q;
      ADR_SV0:  rdata[VEC_W-1:0] = sv0_q;
      ADR_SV1:  rdata[VEC_W-1:0] = sv1_q;
      default: ;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign wdv_o  = wdv_q;
  assign sv0_o  = sv0_q;
  assign sv1_o  = sv1_q;

  assert_pend_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> pend_q == $past(src_req));

  assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADR_MASK) |=> mask_q == $past(wdata[NSRC:1]));
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  localparam int IDX_W = $clog2(NSRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC:1][CTRL_W-1:0] ctrl,
  input  logic [NSRC:1]             mask,
  input  logic [NSRC:1]             pend,
  output logic                      win_valid,
  output logic [IDX_W-1:0]          win_idx,
  output logic [CTRL_W-1:0]         win_ctrl,
  output logic [NSRC:1]             win_oh
);
  logic [NSRC:1]    active;
  logic [KEY_W-1:0] best_key;
  logic             found;

  assign active = pend & ~mask;

  always_comb begin
    found    = 1'b0;
    best_key = '0;
    win_idx  = '0;
    win_ctrl = '0;
    for (int n = 1; n <= NSRC; n++) begin
      if (active[n] && (!found || ctrl[n][KEY_W-1:0] > best_key)) begin
        found    = 1'b1;
        best_key = ctrl[n][KEY_W-1:0];
        win_idx  = IDX_W'(n);
        win_ctrl = ctrl[n];
      end
    end
    win_valid = found && (best_key >= MIN_KEY);
  end

  always_comb begin
    win_oh = '0;
    for (int n = 1; n <= NSRC; n++)
      win_oh[n] = win_valid && (win_idx == IDX_W'(n));
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && ((win_oh & mask) == '0));
endmodule

// File: rtl/prio_irq_vec.sv
module prio_irq_vec
  import prio_irq_pkg::*;
#(
  parameter int NSRC     = NSRC_DEF,
  parameter int WDOG_SRC = 8,
  parameter int SER0_SRC = 12,
  parameter int SER1_SRC = 13,
  localparam int IDX_W = $clog2(NSRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_valid,
  input  logic [IDX_W-1:0]   win_idx,
  input  logic [CTRL_W-1:0]  win_ctrl,
  input  logic [VEC_W-1:0]   wdv,
  input  logic [VEC_W-1:0]   sv0,
  input  logic [VEC_W-1:0]   sv1,
  output logic [LVL_W-1:0]   irq_level,
  output logic [VEC_W-1:0]   irq_vector
);
  logic [LVL_W-1:0] lvl_d, lvl_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic [LVL_W-1:0] win_lvl;

  assign win_lvl = win_ctrl[4:2];

  always_comb begin
    lvl_d = '0;
    vec_d = '0;
    if (win_valid) begin
      lvl_d = win_lvl;
      if (win_ctrl[7])                      vec_d = AUTOVEC_BASE + VEC_W'(win_lvl);
      else if (win_idx == IDX_W'(WDOG_SRC)) vec_d = wdv;
      else if (win_idx == IDX_W'(SER0_SRC)) vec_d = sv0;
      else if (win_idx == IDX_W'(SER1_SRC)) vec_d = sv1;
      else                                  vec_d = FALLBACK_VEC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

  assign irq_level  = lvl_q;
  assign irq_vector = vec_q;

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |-> (irq_vector == '0));

  assert_autovec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ctrl[7]) |=> irq_vector == AUTOVEC_BASE + VEC_W'(irq_level));

  assert_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> irq_level == $past(win_ctrl[4:2]));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC = NSRC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [LVL_W-1:0]  irq_level,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam int IDX_W = $clog2(NSRC + 1);

  logic [NSRC:1][CTRL_W-1:0] ctrl;
  logic [NSRC:1]             mask, pend, win_oh;
  logic [VEC_W-1:0]          wdv, sv0, sv1;
  logic                      win_valid;
  logic [IDX_W-1:0]          win_idx;
  logic [CTRL_W-1:0]         win_ctrl;

  prio_irq_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .ctrl_o(ctrl), .mask_o(mask), .pend_o(pend),
    .wdv_o(wdv), .sv0_o(sv0), .sv1_o(sv1)
  );

  prio_irq_arb #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mask(mask), .pend(pend),
    .win_valid(win_valid), .win_idx(win_idx), .win_ctrl(win_ctrl), .win_oh(win_oh)
  );

  prio_irq_vec #(.NSRC(NSRC)) u_vec (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
    .win_ctrl(win_ctrl), .wdv(wdv), .sv0(sv0), .sv1(sv1),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  localparam int NS = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NS:1] src_req;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  typedef struct { logic [2:0] lvl; logic [7:0] vec; string tag; } exp_t;
  exp_t sb[$];
  int nvec = 0, nmis = 0;

  logic [7:0]  sh_ctrl [1:NS];
  logic [NS:1] sh_mask, sh_req;
  logic [7:0]  sh_wdv, sh_sv0, sh_sv1;

  task automatic model(output logic [2:0] l, output logic [7:0] v);
    int best = -1, idx = 0;
    l = 0; v = 0;
    for (int n = 1; n <= NS; n++)
      if (sh_req[n] && !sh_mask[n] && int'(sh_ctrl[n][4:0]) > best) begin
        best = int'(sh_ctrl[n][4:0]); idx = n;
      end
    if (best >= 4) begin
      l = sh_ctrl[idx][4:2];
      if (sh_ctrl[idx][7]) v = 8'd24 + {5'd0, l};
      else if (idx == 8) v = sh_wdv;
      else if (idx == 12) v = sh_sv0;
      else if (idx == 13) v = sh_sv1;
      else v = 8'h0F;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (a >= 1 && a <= 13) sh_ctrl[a] = d[7:0];
    else if (a == 5'h10) sh_mask = d[NS:1];
    else if (a == 5'h12) sh_wdv = d[7:0];
    else if (a == 5'h13) sh_sv0 = d[7:0];
    else if (a == 5'h14) sh_sv1 = d[7:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_req(input logic [NS:1] r);
    @(negedge clk);
    src_req = r; sh_req = r;
  endtask

  task automatic expect_out(input string tag);
    exp_t e;
    repeat (3) @(posedge clk);
    model(e.lvl, e.vec);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_check(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    nvec++;
    if (reg_rdata !== exp) begin
      nmis++;
      $display("FAIL %s addr %h: got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic out_check(input logic [2:0] l, input logic [7:0] v, input string tag);
    nvec++;
    if (irq_level !== l || irq_vector !== v) begin
      nmis++;
      $display("FAIL %s: got lvl %0d vec %h expected lvl %0d vec %h",
               tag, irq_level, irq_vector, l, v);
    end
  endtask

  // monitor: pops expected items and compares away from the rising edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      out_check(e.lvl, e.vec, e.tag);
    end
  end

  initial begin
    #(200000 * 4);
    nmis++;
    $display("FAIL watchdog expired: got running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_req = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int n = 1; n <= NS; n++)
      sh_ctrl[n] = (n <= 7) ? 8'(n * 4) : (n == 8) ? 8'h1C : (n <= 11) ? 8'h80 : 8'h00;
    sh_mask = '1; sh_req = '0; sh_wdv = 8'h0F; sh_sv0 = 8'h00; sh_sv1 = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    out_check(3'd0, 8'd0, "R1 outputs after reset");
    rd_check(5'h10, 16'h3FFE, "R1 mask reset");
    rd_check(5'h12, 16'h000F, "R1 watchdog vector reset");
    rd_check(5'h13, 16'h0000, "R1 serial vector 0 reset");
    rd_check(5'h14, 16'h0000, "R1 serial vector 1 reset");
    // R2 control resets, R11 map
    for (int n = 1; n <= NS; n++) rd_check(5'(n), {8'h00, sh_ctrl[n]}, "R2 control reset");
    rd_check(5'h1F, 16'h0000, "R11 unmapped reads zero");

    // R6 masked source never presented
    set_req(13'h0040);
    expect_out("R6 all masked, source 7 requested");

    // R10 latency of a mask write
    wr(5'h10, 16'h0000);
    out_check(3'd0, 8'd0, "R10 output unchanged one edge after write");
    @(negedge clk);
    out_check(3'd7, 8'h0F, "R10 output updated on next edge");

    // R3 / R8 fallback vector
    expect_out("R3 source 7 level 7 fallback vector R8");
    // R4 tie between 7 and 8
    set_req(13'h00C0);
    expect_out("R4 tie 7 vs 8 lowest wins");
    // R6 mask 7, then source 8 uses watchdog vector
    wr(5'h10, 16'h0080);
    expect_out("R6 masked 7, source 8 wins");
    wr(5'h12, 16'h0040);
    expect_out("R8 watchdog vector register");
    rd_check(5'h10, 16'h0080, "R6 mask readback");

    // R7 autovector, R3 priority within level
    set_req(13'h0004);
    wr(5'h03, 16'h0095);
    expect_out("R7 autovector level 5");
    wr(5'h04, 16'h0096);
    set_req(13'h000C);
    expect_out("R3 priority within level, source 4");

    // R5 cutoff
    set_req(13'h0100);
    expect_out("R5 key 0 source 9 not presented");
    set_req(13'h0001);
    expect_out("R5 key 4 source 1 presented level 1");
    wr(5'h01, 16'h0003);
    expect_out("R5 key 3 below cutoff");

    // R8 serial vectors
    wr(5'h0C, 16'h000C); wr(5'h13, 16'h0055);
    set_req(13'h0800);
    expect_out("R8 serial vector 0");
    wr(5'h0D, 16'h0010); wr(5'h14, 16'h0066);
    set_req(13'h1800);
    expect_out("R8 serial vector 1 higher level");

    // R9 pending read-only and follows requests
    wr(5'h11, 16'hFFFF);
    rd_check(5'h11, 16'h3000, "R9 pending ignores write");
    set_req(13'h0005);
    @(negedge clk);
    rd_check(5'h11, 16'h000A, "R9 pending follows request");

    // mixed patterns against the requirement model (R3 R4 R6 R7 R8)
    for (int k = 0; k < 40; k++) begin
      int s;
      s = 1 + ($urandom % NS);
      wr(5'(s), 16'($urandom & 8'h9F));
      if (k % 5 == 0) wr(5'h10, 16'($urandom) & 16'h3FFE);
      set_req(13'($urandom));
      expect_out("R3 mixed pattern");
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule